// File: doc/BRIEF.md
# Power-Up and Undervoltage Mute Sequencer

This block orders the startup and fault recovery of a two-channel digitally controlled volume stage. After a power-on reset it keeps the analog outputs in hardware mute. It also holds the rest of the digital logic in reset for a programmable number of clock cycles. It then starts an offset calibration by itself, waits for the calibration circuit to report completion, and issues a one-cycle command that forces both channel gain codes to zero, which is the software-mute setting. After that it hands control to normal operation, where the host may load new gains.

A supply-good flag from an external comparator is watched in every state. When the supply drops, the block falls back into hardware mute with the internal reset asserted. When the supply returns, the whole startup order runs again. In normal operation the hardware mute output follows the active-low mute pin. A new assertion of that pin also starts an offset calibration, which returns straight to normal operation without touching the gain codes. The supply flag and the mute pin are asynchronous and pass through a `SYNC_STAGES`-deep synchronizer. The calibration-done handshake comes from logic on the same clock.

Top module: `pwr_mute_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `hw_mute` is 1, `core_rst_n` is 0, and `cal_start` and `gain_clear` are 0.
- R2: After `rst_n` rises, `core_rst_n` stays 0 and `hw_mute` stays 1 for exactly `RESET_CYCLES` clock cycles.
- R3: In the cycle in which `core_rst_n` first returns to 1, `cal_start` is 1 with no external trigger, and it is 0 in the next cycle (a single-cycle pulse).
- R4: After `cal_start`, the block waits with `hw_mute` at 1 and `gain_clear` at 0 until it samples `cal_done` at 1. A `cal_done` seen outside the calibration wait has no effect.
- R5: In the cycle after `cal_done` is sampled during a startup calibration, `gain_clear` is 1 for exactly one cycle while `hw_mute` is still 1. In the following cycle `hw_mute` is 0 if `mute_n` is high.
- R6: In normal operation, `hw_mute` follows the inverse of `mute_n` with a delay of `SYNC_STAGES` cycles, and `gain_clear` stays 0.
- R7: A falling edge of `mute_n` in normal operation produces a `cal_start` pulse one cycle after `hw_mute` rises. The calibration that follows returns to normal operation on `cal_done` without a `gain_clear`.
- R8: When `supply_ok` goes low in any state, `hw_mute` becomes 1 and `core_rst_n` becomes 0 after `SYNC_STAGES`+1 clock edges. They stay there while the supply is bad, and `cal_done` is ignored during that time.
- R9: When `supply_ok` returns high, the state is reentered `SYNC_STAGES`+1 edges later and the full startup order repeats: `RESET_CYCLES` cycles of reset, a `cal_start` pulse, and a `gain_clear` after `cal_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_ok | input | 1 | Asynchronous supply-good flag from the comparator, 1 = good |
| mute_n | input | 1 | Asynchronous hardware mute pin, 0 = mute |
| cal_done | input | 1 | Offset calibration finished, sampled while waiting |
| hw_mute | output | 1 | Disconnects the analog outputs when 1 |
| core_rst_n | output | 1 | Active-low reset for the other digital logic |
| cal_start | output | 1 | One-cycle request to start an offset calibration |
| gain_clear | output | 1 | One-cycle command to force both gain codes to zero |

## Verification
The hardest case to reach is a supply loss in the middle of a calibration, with `cal_done` arriving after the fault. The bench starts a normal power-up and stops it in the calibration wait just after the `cal_start` pulse. It then drops `supply_ok` and raises `cal_done` in the cycles that follow. It checks that no `gain_clear` appears and that the reset is asserted again on schedule. A second hard case is the calibration started by the mute pin. The bench releases the pin while that calibration is still running, so it can confirm that the exit goes to normal operation without a `gain_clear`.

// File: rtl/pms_pkg.sv
// Shared types for the power-up / undervoltage mute sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pms_pkg;

    // Sequencer states, in startup order.
    typedef enum logic [2:0] {
        ST_RESET_WAIT = 3'd0,
        ST_CALIBRATE  = 3'd1,
        ST_INIT_GAIN  = 3'd2,
        ST_RUN        = 3'd3,
        ST_UV_MUTE    = 3'd4
    } seq_state_t;

endpackage

// File: rtl/pms_sync.sv
// Multi-bit, multi-stage synchronizer for independent asynchronous level inputs.
// Assumes: each bit is a slow level and no bit-to-bit coherence is needed.
// The reset value of each bit is set by RST_VAL.
module pms_sync #(
    parameter int unsigned        WIDTH   = 2,
    parameter int unsigned        STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d_async;
                end
            end else begin : g_next
                // Later stages resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pms_timer.sv
// Reset-hold interval timer: counts cycles while 'run' is high.
// 'expired' is high in the LIMIT-th consecutive run cycle.
// Assumes: LIMIT >= 1; the count clears whenever run is low.
module pms_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Counts while running and restarts from zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

    // R2: each running cycle before expiry advances the count by one.
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expired) |=> (!run || cnt == $past(cnt) + 1'b1));

    // R2: an idle cycle leaves the count at zero.
    a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/pms_fsm.sv
// Startup / fault-recovery state machine.
// Orders the sequence: reset hold, calibration, gain clear, run.
// Any loss of supply goes to undervoltage mute.
// Assumes: supply_s and muted are already synchronized; cal_done is on clk.
module pms_fsm
    import pms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_s,
    input  logic muted,
    input  logic cal_done,
    input  logic hold_expired,
    output logic hold_run,
    output logic hw_mute,
    output logic core_rst_n,
    output logic cal_start,
    output logic gain_clear
);

    seq_state_t state, nxt;
    logic       cal_ret;    // calibration was started by the mute pin
    logic       muted_q;
    logic       mute_rise;

    assign mute_rise = muted && !muted_q;

    // Next-state selection; a bad supply overrides every other transition.
    always_comb begin
        nxt = state;
        case (state)
            ST_RESET_WAIT: if (hold_expired) nxt = ST_CALIBRATE;
            ST_CALIBRATE:  if (cal_done)     nxt = cal_ret ? ST_RUN : ST_INIT_GAIN;
            ST_INIT_GAIN:                    nxt = ST_RUN;
            ST_RUN:        if (mute_rise)    nxt = ST_CALIBRATE;
            ST_UV_MUTE:                      nxt = ST_RESET_WAIT;
            default:                         nxt = ST_UV_MUTE;
        endcase
        if (!supply_s) nxt = ST_UV_MUTE;
    end

    // State, calibration pulse, calibration origin and mute history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RESET_WAIT;
            cal_start <= 1'b0;
            cal_ret   <= 1'b0;
            muted_q   <= 1'b0;
        end else begin
            state     <= nxt;
            cal_start <= (nxt == ST_CALIBRATE) && (state != ST_CALIBRATE);
            if ((nxt == ST_CALIBRATE) && (state != ST_CALIBRATE))
                cal_ret <= (state == ST_RUN);
            muted_q   <= muted;
        end
    end

    // Moore outputs decoded from the state.
    always_comb begin
        hold_run   = (state == ST_RESET_WAIT);
        core_rst_n = !((state == ST_RESET_WAIT) || (state == ST_UV_MUTE));
        gain_clear = (state == ST_INIT_GAIN);
        hw_mute    = (state != ST_RUN) || muted;
    end

    // R3: the calibration request lasts a single cycle.
    a_r3_cal_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R4: the calibration wait holds until cal_done, unless the supply fails.
    a_r4_cal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALIBRATE && !cal_done && supply_s) |=> (state == ST_CALIBRATE));

    // R5: the gain clear is never two cycles in a row.
    a_r5_clear_once: assert property (@(posedge clk) disable iff (!rst_n)
        gain_clear |=> !gain_clear);

    // R7: a new mute assertion in run requests calibration next cycle.
    a_r7_mute_cal: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && mute_rise && supply_s) |=> cal_start);

    // R8: a bad supply always lands in undervoltage mute.
    a_r8_uv_enter: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_s |=> (state == ST_UV_MUTE && !core_rst_n && hw_mute));

    // R9: recovery restarts from the reset hold.
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UV_MUTE && supply_s) |=> (state == ST_RESET_WAIT));

endmodule

// File: rtl/pwr_mute_seq.sv
// Top level of the power-up and undervoltage mute sequencer.
// Synchronizes the asynchronous supply flag and mute pin, times the reset
// hold and runs the sequencing state machine.
// Assumes: supply is good when rst_n releases (power-on reset).
module pwr_mute_seq #(
    parameter int unsigned RESET_CYCLES = 1228800,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic mute_n,
    input  logic cal_done,
    output logic hw_mute,
    output logic core_rst_n,
    output logic cal_start,
    output logic gain_clear
);

    logic [1:0] async_in;
    logic [1:0] sync_out;
    logic       hold_run;
    logic       hold_expired;

    assign async_in = {supply_ok, mute_n};

    pms_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (async_in),
        .q_sync  (sync_out)
    );

    pms_timer #(
        .LIMIT   (RESET_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hold_run),
        .expired (hold_expired)
    );

    pms_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_s     (sync_out[1]),
        .muted        (!sync_out[0]),
        .cal_done     (cal_done),
        .hold_expired (hold_expired),
        .hold_run     (hold_run),
        .hw_mute      (hw_mute),
        .core_rst_n   (core_rst_n),
        .cal_start    (cal_start),
        .gain_clear   (gain_clear)
    );

endmodule

// File: tb/tb_pwr_mute_seq.sv
// Directed bench for the mute sequencer: one task per scenario.
module tb_pwr_mute_seq;

    localparam int CLK_PERIOD = 10;
    localparam int RC = 20;
    localparam int SS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic mute_n = 1'b1;
    logic cal_done = 1'b0;
    logic hw_mute, core_rst_n, cal_start, gain_clear;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mute_seq #(.RESET_CYCLES(RC), .SYNC_STAGES(SS)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mute_n(mute_n),
        .cal_done(cal_done), .hw_mute(hw_mute), .core_rst_n(core_rst_n),
        .cal_start(cal_start), .gain_clear(gain_clear)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // R1, R2, R3, R4, R5: reset release through to run.
    task automatic t_powerup();
        rst_n = 1'b0; supply_ok = 1'b1; mute_n = 1'b1; cal_done = 1'b0;
        tick(3);
        check("R1", "hw_mute in reset", hw_mute, 1'b1);
        check("R1", "core_rst_n in reset", core_rst_n, 1'b0);
        check("R1", "cal_start in reset", cal_start, 1'b0);
        check("R1", "gain_clear in reset", gain_clear, 1'b0);
        rst_n = 1'b1;
        tick(1);
        check("R1", "core_rst_n after release", core_rst_n, 1'b0);
        tick(RC - 2);
        check("R2", "core_rst_n last hold cycle", core_rst_n, 1'b0);
        check("R2", "hw_mute last hold cycle", hw_mute, 1'b1);
        check("R2", "cal_start during hold", cal_start, 1'b0);
        tick(1);
        check("R3", "core_rst_n released", core_rst_n, 1'b1);
        check("R3", "cal_start pulse", cal_start, 1'b1);
        tick(1);
        check("R3", "cal_start ends", cal_start, 1'b0);
        tick(4);
        check("R4", "hw_mute waiting", hw_mute, 1'b1);
        check("R4", "gain_clear waiting", gain_clear, 1'b0);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
        check("R5", "gain_clear after done", gain_clear, 1'b1);
        check("R5", "hw_mute during clear", hw_mute, 1'b1);
        tick(1);
        check("R5", "gain_clear one cycle", gain_clear, 1'b0);
        check("R5", "hw_mute released", hw_mute, 1'b0);
    endtask

    // R4: cal_done during the reset hold is ignored.
    task automatic t_early_done();
        rst_n = 1'b0; cal_done = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(3);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
        check("R4", "early done keeps reset", core_rst_n, 1'b0);
        tick(RC - 5);
        check("R4", "hold length unchanged", core_rst_n, 1'b0);
        tick(1);
        check("R4", "cal_start after early done", cal_start, 1'b1);
        tick(4);
        check("R4", "still waiting, no clear", gain_clear, 1'b0);
        check("R4", "still waiting, muted", hw_mute, 1'b1);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
        check("R4", "clear follows real done", gain_clear, 1'b1);
        tick(1);
    endtask

    // R6, R7: mute pin following and mute-triggered calibration.
    task automatic t_mute();
        mute_n = 1'b0;
        tick(SS - 1);
        check("R6", "hw_mute before sync latency", hw_mute, 1'b0);
        tick(1);
        check("R6", "hw_mute after sync latency", hw_mute, 1'b1);
        check("R7", "no cal_start yet", cal_start, 1'b0);
        tick(1);
        check("R7", "cal_start on mute", cal_start, 1'b1);
        tick(1);
        check("R7", "cal_start single", cal_start, 1'b0);
        tick(2);
        check("R7", "hw_mute during mute cal", hw_mute, 1'b1);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
        check("R7", "no gain_clear after mute cal", gain_clear, 1'b0);
        check("R7", "still muted by pin", hw_mute, 1'b1);
        tick(1);
        check("R7", "no gain_clear next cycle", gain_clear, 1'b0);
        mute_n = 1'b1;
        tick(SS - 1);
        check("R6", "hw_mute held during latency", hw_mute, 1'b1);
        tick(1);
        check("R6", "hw_mute follows release", hw_mute, 1'b0);
        check("R6", "gain_clear stays low", gain_clear, 1'b0);
        tick(2);
        check("R6", "no cal_start on release", cal_start, 1'b0);
    endtask

    // R7: mute released during its own calibration; exit goes straight to run.
    task automatic t_mute_release_in_cal();
        mute_n = 1'b0;
        tick(SS + 1);
        check("R7", "cal_start on second mute", cal_start, 1'b1);
        mute_n = 1'b1;
        tick(4);
        check("R7", "muted while calibrating", hw_mute, 1'b1);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
        check("R7", "run without clear", gain_clear, 1'b0);
        check("R7", "unmuted in run", hw_mute, 1'b0);
    endtask

    // R8, R9: undervoltage from run and recovery.
    task automatic t_uv_from_run();
        supply_ok = 1'b0;
        tick(SS);
        check("R8", "core_rst_n before uv", core_rst_n, 1'b1);
        check("R8", "hw_mute before uv", hw_mute, 1'b0);
        tick(1);
        check("R8", "hw_mute in uv", hw_mute, 1'b1);
        check("R8", "core_rst_n in uv", core_rst_n, 1'b0);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
        check("R8", "done ignored, no clear", gain_clear, 1'b0);
        check("R8", "done ignored, no cal", cal_start, 1'b0);
        tick(8);
        check("R8", "uv held", core_rst_n, 1'b0);
        supply_ok = 1'b1;
        tick(SS + 1);
        check("R9", "reset on reentry", core_rst_n, 1'b0);
        tick(RC - 1);
        check("R9", "hold before restart cal", core_rst_n, 1'b0);
        check("R9", "muted through hold", hw_mute, 1'b1);
        tick(1);
        check("R9", "cal_start after recovery", cal_start, 1'b1);
        check("R9", "core_rst_n after recovery", core_rst_n, 1'b1);
        tick(2);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
        check("R9", "gain_clear after recovery", gain_clear, 1'b1);
        tick(1);
        check("R9", "back in run", hw_mute, 1'b0);
    endtask

    // R8: supply lost during a startup calibration, cal_done arrives later.
    task automatic t_uv_in_cal();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(RC);
        check("R8", "cal_start before fault", cal_start, 1'b1);
        tick(1);
        supply_ok = 1'b0;
        tick(SS + 1);
        check("R8", "reset reasserted in cal", core_rst_n, 1'b0);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
        check("R8", "no clear after late done", gain_clear, 1'b0);
        tick(1);
        check("R8", "no clear later", gain_clear, 1'b0);
        check("R8", "still muted", hw_mute, 1'b1);
        supply_ok = 1'b1;
        tick(SS + 1 + RC);
        check("R9", "restart cal after fault", cal_start, 1'b1);
    endtask

    initial begin
        t_powerup();
        t_early_done();
        t_mute();
        t_mute_release_in_cal();
        t_uv_from_run();
        t_uv_in_cal();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule